// File: doc/BRIEF.md
# Register-to-Register Execute Stage

This block is the decode-and-execute stage of a small 32-bit load/store processor core. In each cycle it receives one instruction word, the program counter of that instruction, and three operand values read from a sixteen-entry register file: the two sources and the register named by the destination field. It produces a registered write-back request, a branch-redirect request, a load/store strobe with its address, and an illegal-opcode flag.

Arithmetic, logical, move, shift and compare opcodes all pass through one shared ALU. An operand selector places a register, the PC, the sign-extended immediate or zero on each ALU input. Branches are resolved in the same cycle as the ALU operation. Memory opcodes are only decoded into a strobe and an address here; the data memory is outside the block. All outputs appear one clock after the inputs are presented. Any output that is not in use for the current instruction is held at zero.

Top module: `exec_stage`

## Requirements
- R1: The instruction fields are: opcode in bits 31:24, destination index in 23:20, first source in 19:16, second source in 15:12, immediate in 15:0, and shift amount in 4:0. Every output reflects the inputs sampled at the previous rising clock edge.
- R2: Opcode 0 writes src1+src2. Opcode 1 writes src1 plus the sign-extended immediate. Opcode 2 writes the PC plus the sign-extended immediate.
- R3: Opcodes 3, 4 and 5 subtract, with the same three operand forms as R2 (src1−src2, src1−imm, PC−imm).
- R4: Opcode 6 writes src1, opcode 7 writes the sign-extended immediate, opcode 8 writes the PC, opcode 9 writes the two's-complement negation of src1, and opcode 14 writes the bitwise inverse of src1.
- R5: Opcodes 10 and 11 write src1 AND src2 and src1 AND the sign-extended immediate. Opcodes 12 and 13 do the same with OR.
- R6: Opcode 15 shifts src1 left and opcode 16 shifts it right arithmetically. The shift distance is bits 4:0 read as an unsigned number; the other immediate bits are ignored.
- R7: Opcode 17 writes all-ones when src1 equals src2, otherwise zero. Opcode 18 writes all-ones when src1 is greater than src2 as signed two's-complement, otherwise zero.
- R8: Opcode 19 raises the redirect with target equal to the destination register's value only when src1 is all-ones. Opcode 20 always does so. Neither writes a register.
- R9: Opcode 21 raises the load strobe and opcode 22 the store strobe, with the address equal to the src2 value. Neither writes a register.
- R10: Opcode 23 has no effect on any output. Opcodes 24 to 255 have no effect other than raising the illegal flag for the one result cycle of that instruction.
- R11: At most one of write-enable, redirect, load, store and illegal is high in any cycle. When the associated event is inactive, the write index, write data, redirect target and memory address are zero.
- R12: While the active-low reset is low, every output is zero, and this takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word being executed |
| pc_i | input | 32 | Program counter of that instruction |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| rd_val_i | input | 32 | Value of the register named by the destination field |
| wb_en_o | output | 1 | Register write request |
| wb_idx_o | output | 4 | Register index to write |
| wb_data_o | output | 32 | Data to write |
| br_valid_o | output | 1 | Redirect request |
| br_target_o | output | 32 | Redirect target address |
| mem_ld_o | output | 1 | Load strobe |
| mem_st_o | output | 1 | Store strobe |
| mem_addr_o | output | 32 | Memory address for load or store |
| illegal_o | output | 1 | Undefined opcode seen |

## Verification
The hardest cases to reach from the ports are those where opcode bits or immediate bits are present but must not matter. Examples are a shift whose immediate has ones above bit 4, a conditional branch whose src1 is one bit short of all-ones, and an undefined opcode followed directly by a no-op, where the flag must fall after exactly one cycle. The vector table places each of these directly after an instruction that would leave the opposite value on the outputs, so a stale or leaked result is visible. Signed comparison is checked with operand pairs whose unsigned order is the reverse of their signed order.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int INSTR_W = 32;
    localparam int OPC_W   = 8;
    localparam int OPC_LO  = 24;
    localparam int DST_LO  = 20;
    localparam int S1_LO   = 16;
    localparam int IMM_W   = 16;

    localparam logic [OPC_W-1:0] OPC_ADD_RR = 8'd0;
    localparam logic [OPC_W-1:0] OPC_ADD_RI = 8'd1;
    localparam logic [OPC_W-1:0] OPC_ADD_PI = 8'd2;
    localparam logic [OPC_W-1:0] OPC_SUB_RR = 8'd3;
    localparam logic [OPC_W-1:0] OPC_SUB_RI = 8'd4;
    localparam logic [OPC_W-1:0] OPC_SUB_PI = 8'd5;
    localparam logic [OPC_W-1:0] OPC_MOV_R  = 8'd6;
    localparam logic [OPC_W-1:0] OPC_MOV_I  = 8'd7;
    localparam logic [OPC_W-1:0] OPC_MOV_P  = 8'd8;
    localparam logic [OPC_W-1:0] OPC_NEG    = 8'd9;
    localparam logic [OPC_W-1:0] OPC_AND_RR = 8'd10;
    localparam logic [OPC_W-1:0] OPC_AND_RI = 8'd11;
    localparam logic [OPC_W-1:0] OPC_OR_RR  = 8'd12;
    localparam logic [OPC_W-1:0] OPC_OR_RI  = 8'd13;
    localparam logic [OPC_W-1:0] OPC_INV    = 8'd14;
    localparam logic [OPC_W-1:0] OPC_SHL    = 8'd15;
    localparam logic [OPC_W-1:0] OPC_SHR    = 8'd16;
    localparam logic [OPC_W-1:0] OPC_CMPEQ  = 8'd17;
    localparam logic [OPC_W-1:0] OPC_CMPGT  = 8'd18;
    localparam logic [OPC_W-1:0] OPC_BRT    = 8'd19;
    localparam logic [OPC_W-1:0] OPC_BRA    = 8'd20;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 8'd21;
    localparam logic [OPC_W-1:0] OPC_STORE  = 8'd22;
    localparam logic [OPC_W-1:0] OPC_IDLE   = 8'd23;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_INV, FN_SHL, FN_SRA, FN_EQ, FN_GT
    } alu_fn_e;

    typedef enum logic [1:0] { A_RS1, A_PC, A_ZERO } a_sel_e;
    typedef enum logic [1:0] { B_RS2, B_IMM, B_RS1, B_ZERO } b_sel_e;

    typedef struct packed {
        alu_fn_e fn;
        a_sel_e  a_sel;
        b_sel_e  b_sel;
        logic    wr;
        logic    br_cond;
        logic    br_always;
        logic    ld;
        logic    st;
        logic    bad;
    } ctrl_t;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output ctrl_t            ctrl_o
);
    always_comb begin
        ctrl_o = '{fn: FN_ADD, a_sel: A_ZERO, b_sel: B_ZERO, default: 1'b0};
        case (opc_i)
            OPC_ADD_RR: begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_ADD_RI: begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_ADD_PI: begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_PC;   ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_SUB_RR: begin ctrl_o.fn = FN_SUB; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_SUB_RI: begin ctrl_o.fn = FN_SUB; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_SUB_PI: begin ctrl_o.fn = FN_SUB; ctrl_o.a_sel = A_PC;   ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_MOV_R:  begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_ZERO; ctrl_o.wr = 1'b1; end
            OPC_MOV_I:  begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_ZERO; ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_MOV_P:  begin ctrl_o.fn = FN_ADD; ctrl_o.a_sel = A_PC;   ctrl_o.b_sel = B_ZERO; ctrl_o.wr = 1'b1; end
            OPC_NEG:    begin ctrl_o.fn = FN_SUB; ctrl_o.a_sel = A_ZERO; ctrl_o.b_sel = B_RS1;  ctrl_o.wr = 1'b1; end
            OPC_AND_RR: begin ctrl_o.fn = FN_AND; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_AND_RI: begin ctrl_o.fn = FN_AND; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_OR_RR:  begin ctrl_o.fn = FN_OR;  ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_OR_RI:  begin ctrl_o.fn = FN_OR;  ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_INV:    begin ctrl_o.fn = FN_INV; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_ZERO; ctrl_o.wr = 1'b1; end
            OPC_SHL:    begin ctrl_o.fn = FN_SHL; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_SHR:    begin ctrl_o.fn = FN_SRA; ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_IMM;  ctrl_o.wr = 1'b1; end
            OPC_CMPEQ:  begin ctrl_o.fn = FN_EQ;  ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_CMPGT:  begin ctrl_o.fn = FN_GT;  ctrl_o.a_sel = A_RS1;  ctrl_o.b_sel = B_RS2;  ctrl_o.wr = 1'b1; end
            OPC_BRT:    ctrl_o.br_cond   = 1'b1;
            OPC_BRA:    ctrl_o.br_always = 1'b1;
            OPC_LOAD:   ctrl_o.ld        = 1'b1;
            OPC_STORE:  ctrl_o.st        = 1'b1;
            OPC_IDLE:   ;
            default:    ctrl_o.bad       = 1'b1;
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e           fn_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    assign shamt = b_i[SH_W-1:0];

    always_comb begin
        case (fn_i)
            FN_ADD:  res_o = a_i + b_i;
            FN_SUB:  res_o = a_i - b_i;
            FN_AND:  res_o = a_i & b_i;
            FN_OR:   res_o = a_i | b_i;
            FN_INV:  res_o = ~a_i;
            FN_SHL:  res_o = a_i << shamt;
            FN_SRA:  res_o = $unsigned($signed(a_i) >>> shamt);
            FN_EQ:   res_o = (a_i == b_i) ? '1 : '0;
            FN_GT:   res_o = ($signed(a_i) > $signed(b_i)) ? '1 : '0;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (fn_i == FN_EQ || fn_i == FN_GT) begin
            // R7
            cmp_mask_chk: assert (res_o == '0 || res_o == '1);
        end
    end
endmodule

// File: rtl/exec_branch.sv
module exec_branch #(
    parameter int DATA_W = 32
) (
    input  logic              cond_i,
    input  logic              always_i,
    input  logic [DATA_W-1:0] test_val_i,
    input  logic [DATA_W-1:0] dest_val_i,
    output logic              take_o,
    output logic [DATA_W-1:0] target_o
);
    logic all_ones;
    assign all_ones = &test_val_i;
    assign take_o   = always_i | (cond_i & all_ones);
    assign target_o = take_o ? dest_val_i : '0;
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [DATA_W-1:0]   pc_i,
    input  logic [DATA_W-1:0]   rs1_val_i,
    input  logic [DATA_W-1:0]   rs2_val_i,
    input  logic [DATA_W-1:0]   rd_val_i,
    output logic                wb_en_o,
    output logic [IDX_W-1:0]    wb_idx_o,
    output logic [DATA_W-1:0]   wb_data_o,
    output logic                br_valid_o,
    output logic [DATA_W-1:0]   br_target_o,
    output logic                mem_ld_o,
    output logic                mem_st_o,
    output logic [DATA_W-1:0]   mem_addr_o,
    output logic                illegal_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        logic              wb_en;
        logic [IDX_W-1:0]  wb_idx;
        logic [DATA_W-1:0] wb_data;
        logic              br_valid;
        logic [DATA_W-1:0] br_target;
        logic              ld;
        logic              st;
        logic [DATA_W-1:0] addr;
        logic              bad;
    } stage_t;

    stage_t stage_d, stage_q;

    logic [OPC_W-1:0]  opc;
    logic [IDX_W-1:0]  dst_idx;
    logic [DATA_W-1:0] imm_ext;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] op_a, op_b, alu_res;
    logic              br_take;
    logic [DATA_W-1:0] br_tgt;

    assign opc     = instr_i[OPC_LO +: OPC_W];
    assign dst_idx = instr_i[DST_LO +: IDX_W];
    assign imm_ext = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};

    exec_decode u_dec (
        .opc_i  (opc),
        .ctrl_o (ctrl)
    );

    always_comb begin
        case (ctrl.a_sel)
            A_RS1:   op_a = rs1_val_i;
            A_PC:    op_a = pc_i;
            default: op_a = '0;
        endcase
        case (ctrl.b_sel)
            B_RS2:   op_b = rs2_val_i;
            B_IMM:   op_b = imm_ext;
            B_RS1:   op_b = rs1_val_i;
            default: op_b = '0;
        endcase
    end

    exec_alu #(.DATA_W(DATA_W)) u_alu (
        .fn_i  (ctrl.fn),
        .a_i   (op_a),
        .b_i   (op_b),
        .res_o (alu_res)
    );

    exec_branch #(.DATA_W(DATA_W)) u_br (
        .cond_i     (ctrl.br_cond),
        .always_i   (ctrl.br_always),
        .test_val_i (rs1_val_i),
        .dest_val_i (rd_val_i),
        .take_o     (br_take),
        .target_o   (br_tgt)
    );

    always_comb begin
        stage_d           = '0;
        stage_d.wb_en     = ctrl.wr;
        stage_d.wb_idx    = ctrl.wr ? dst_idx : '0;
        stage_d.wb_data   = ctrl.wr ? alu_res : '0;
        stage_d.br_valid  = br_take;
        stage_d.br_target = br_tgt;
        stage_d.ld        = ctrl.ld;
        stage_d.st        = ctrl.st;
        stage_d.addr      = (ctrl.ld | ctrl.st) ? rs2_val_i : '0;
        stage_d.bad       = ctrl.bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign wb_en_o     = stage_q.wb_en;
    assign wb_idx_o    = stage_q.wb_idx;
    assign wb_data_o   = stage_q.wb_data;
    assign br_valid_o  = stage_q.br_valid;
    assign br_target_o = stage_q.br_target;
    assign mem_ld_o    = stage_q.ld;
    assign mem_st_o    = stage_q.st;
    assign mem_addr_o  = stage_q.addr;
    assign illegal_o   = stage_q.bad;

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en_o, br_valid_o, mem_ld_o, mem_st_o, illegal_o}));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en_o |-> (wb_data_o == '0 && wb_idx_o == '0));

    // R8
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[OPC_LO +: OPC_W] == OPC_BRA) |=>
            (br_valid_o && !wb_en_o && br_target_o == $past(rd_val_i)));

    // R9
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[OPC_LO +: OPC_W] == OPC_LOAD) |=>
            (mem_ld_o && !wb_en_o && mem_addr_o == $past(rs2_val_i)));

    // R10
    bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (illegal_o == ($past(instr_i[OPC_LO +: OPC_W]) > OPC_IDLE)));

    // R1
    dst_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_idx_o == $past(instr_i[DST_LO +: IDX_W])));
endmodule

// File: tb/sim_exec_stage.sv
`timescale 1ns/1ps
module sim_exec_stage;
    localparam int K_WB = 0, K_BR = 1, K_LD = 2, K_ST = 3, K_NONE = 4, K_ILL = 5;
    localparam int NV = 34;
    localparam int OUT_W = 105;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] d;
        logic [2:0]  kind;
        logic [3:0]  req;
        logic [31:0] val;
    } vec_t;

    function automatic logic [31:0] mk(input logic [7:0] op, input logic [3:0] dst,
                                       input logic [3:0] s1, input logic [15:0] lo);
        return {op, dst, s1, lo};
    endfunction

    localparam vec_t VECS [NV] = '{
        '{mk(8'd0,  4'd3, 4'd1,16'h2000), 32'h0,    32'd5,        32'd7,        32'h0,   3'd0, 4'd2, 32'd12},        // R2
        '{mk(8'd1,  4'd4, 4'd2,16'hFFF6), 32'h0,    32'd100,      32'h0,        32'h0,   3'd0, 4'd2, 32'd90},        // R2
        '{mk(8'd2,  4'd5, 4'd0,16'h0010), 32'h1000, 32'h0,        32'h0,        32'h0,   3'd0, 4'd2, 32'h1010},      // R2
        '{mk(8'd3,  4'd6, 4'd1,16'h2000), 32'h0,    32'd5,        32'd7,        32'h0,   3'd0, 4'd3, 32'hFFFFFFFE},  // R3
        '{mk(8'd4,  4'd7, 4'd1,16'h0001), 32'h0,    32'h0,        32'h0,        32'h0,   3'd0, 4'd3, 32'hFFFFFFFF},  // R3
        '{mk(8'd5,  4'd8, 4'd0,16'hFFFF), 32'h1000, 32'h0,        32'h0,        32'h0,   3'd0, 4'd3, 32'h1001},      // R3
        '{mk(8'd6,  4'd9, 4'd1,16'h0000), 32'h0,    32'hDEADBEEF, 32'h5,        32'h0,   3'd0, 4'd4, 32'hDEADBEEF},  // R4
        '{mk(8'd7,  4'd10,4'd0,16'h8000), 32'h0,    32'h11,       32'h0,        32'h0,   3'd0, 4'd4, 32'hFFFF8000},  // R4
        '{mk(8'd8,  4'd11,4'd0,16'h0000), 32'h2468, 32'h0,        32'h0,        32'h0,   3'd0, 4'd4, 32'h2468},      // R4
        '{mk(8'd9,  4'd12,4'd1,16'h0000), 32'h0,    32'd1,        32'h0,        32'h0,   3'd0, 4'd4, 32'hFFFFFFFF},  // R4
        '{mk(8'd14, 4'd13,4'd1,16'h0000), 32'h0,    32'h0F0F0F0F, 32'h0,        32'h0,   3'd0, 4'd4, 32'hF0F0F0F0},  // R4
        '{mk(8'd10, 4'd14,4'd1,16'h2000), 32'h0,    32'hF0F0F0F0, 32'h0FF00FF0, 32'h0,   3'd0, 4'd5, 32'h00F000F0},  // R5
        '{mk(8'd11, 4'd15,4'd1,16'h8001), 32'h0,    32'h12345678, 32'h0,        32'h0,   3'd0, 4'd5, 32'h12340000},  // R5
        '{mk(8'd12, 4'd1, 4'd1,16'h2000), 32'h0,    32'hF0000000, 32'h0000000F, 32'h0,   3'd0, 4'd5, 32'hF000000F},  // R5
        '{mk(8'd13, 4'd2, 4'd1,16'h8000), 32'h0,    32'h0,        32'h0,        32'h0,   3'd0, 4'd5, 32'hFFFF8000},  // R5
        '{mk(8'd15, 4'd3, 4'd1,16'hFFE4), 32'h0,    32'd3,        32'h0,        32'h0,   3'd0, 4'd6, 32'h30},        // R6
        '{mk(8'd16, 4'd4, 4'd1,16'h0004), 32'h0,    32'h80000000, 32'h0,        32'h0,   3'd0, 4'd6, 32'hF8000000},  // R6
        '{mk(8'd16, 4'd5, 4'd1,16'h001F), 32'h0,    32'h40000000, 32'h0,        32'h0,   3'd0, 4'd6, 32'h0},         // R6
        '{mk(8'd15, 4'd6, 4'd1,16'h001F), 32'h0,    32'd1,        32'h0,        32'h0,   3'd0, 4'd6, 32'h80000000},  // R6
        '{mk(8'd17, 4'd7, 4'd1,16'h2000), 32'h0,    32'd7,        32'd7,        32'h0,   3'd0, 4'd7, 32'hFFFFFFFF},  // R7
        '{mk(8'd17, 4'd8, 4'd1,16'h2000), 32'h0,    32'd7,        32'd8,        32'h0,   3'd0, 4'd7, 32'h0},         // R7
        '{mk(8'd18, 4'd9, 4'd1,16'h2000), 32'h0,    32'd1,        32'hFFFFFFFF, 32'h0,   3'd0, 4'd7, 32'hFFFFFFFF},  // R7
        '{mk(8'd18, 4'd10,4'd1,16'h2000), 32'h0,    32'hFFFFFFFF, 32'd1,        32'h0,   3'd0, 4'd7, 32'h0},         // R7
        '{mk(8'd18, 4'd11,4'd1,16'h2000), 32'h0,    32'd5,        32'd5,        32'h0,   3'd0, 4'd7, 32'h0},         // R7
        '{mk(8'd19, 4'd12,4'd1,16'h2000), 32'h0,    32'hFFFFFFFF, 32'h0,        32'h400, 3'd1, 4'd8, 32'h400},       // R8
        '{mk(8'd19, 4'd12,4'd1,16'h2000), 32'h0,    32'hFFFFFFFE, 32'h0,        32'h400, 3'd4, 4'd8, 32'h0},         // R8
        '{mk(8'd20, 4'd13,4'd0,16'h0000), 32'h0,    32'h0,        32'h0,        32'h800, 3'd1, 4'd8, 32'h800},       // R8
        '{mk(8'd21, 4'd14,4'd0,16'h3000), 32'h0,    32'h0,        32'h123,      32'h0,   3'd2, 4'd9, 32'h123},       // R9
        '{mk(8'd22, 4'd15,4'd0,16'h3000), 32'h0,    32'h0,        32'h456,      32'h99,  3'd3, 4'd9, 32'h456},       // R9
        '{mk(8'd23, 4'd1, 4'd2,16'h3000), 32'h10,   32'h77,       32'h66,       32'h55,  3'd4, 4'd10,32'h0},         // R10
        '{mk(8'd24, 4'd2, 4'd1,16'h1234), 32'h0,    32'h1,        32'h2,        32'h3,   3'd5, 4'd10,32'h0},         // R10
        '{mk(8'd255,4'd3, 4'd1,16'h0000), 32'h0,    32'h1,        32'h2,        32'h3,   3'd5, 4'd10,32'h0},         // R10
        '{mk(8'd23, 4'd0, 4'd0,16'h0000), 32'h0,    32'h0,        32'h0,        32'h0,   3'd4, 4'd10,32'h0},         // R10
        '{mk(8'd1,  4'd15,4'd15,16'h7FFF),32'h0,    32'd1,        32'h0,        32'h0,   3'd0, 4'd1, 32'h8000}       // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0, pc = '0, rs1 = '0, rs2 = '0, rdv = '0;
    logic        wb_en, br_valid, mem_ld, mem_st, illegal;
    logic [3:0]  wb_idx;
    logic [31:0] wb_data, br_target, mem_addr;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    exec_stage u0 (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .pc_i(pc),
        .rs1_val_i(rs1), .rs2_val_i(rs2), .rd_val_i(rdv),
        .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data),
        .br_valid_o(br_valid), .br_target_o(br_target),
        .mem_ld_o(mem_ld), .mem_st_o(mem_st), .mem_addr_o(mem_addr),
        .illegal_o(illegal)
    );

    function automatic logic [OUT_W-1:0] actual();
        return {wb_en, wb_idx, wb_data, br_valid, br_target, mem_ld, mem_st, mem_addr, illegal};
    endfunction

    function automatic logic [OUT_W-1:0] expect_of(input vec_t v);
        logic w, br, ld, st;
        w  = (v.kind == 3'(K_WB));
        br = (v.kind == 3'(K_BR));
        ld = (v.kind == 3'(K_LD));
        st = (v.kind == 3'(K_ST));
        return {w, w ? v.instr[23:20] : 4'h0, w ? v.val : 32'h0,
                br, br ? v.val : 32'h0, ld, st, (ld | st) ? v.val : 32'h0,
                v.kind == 3'(K_ILL)};
    endfunction

    task automatic check(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        instr = v.instr; pc = v.pc; rs1 = v.a; rs2 = v.b; rdv = v.d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t hold;
        instr = mk(8'd20, 4'd1, 4'd0, 16'h0); rdv = 32'h1234;
        repeat (2) @(posedge clk);
        #2;
        // R12: outputs held at zero during reset despite a jump at the inputs
        check("R12 reset", actual(), '0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), actual(), expect_of(VECS[i]));
        end

        // R1: a new instruction does not reach the outputs before the clock edge
        hold = VECS[7];
        drive(VECS[0]);
        @(negedge clk);
        instr = hold.instr; pc = hold.pc; rs1 = hold.a; rs2 = hold.b; rdv = hold.d;
        #2;
        check("R1 latency", actual(), expect_of(VECS[0]));
        @(posedge clk);
        #2;
        check("R1 after edge", actual(), expect_of(hold));

        // R11: a store leaves write and redirect fields at zero
        drive(VECS[28]);
        check("R11 store quiet", {wb_en, wb_idx, wb_data, br_valid, br_target},
              {{(OUT_W-69){1'b0}}, 69'h0});

        // R12: reset applied between edges clears results at once
        drive(VECS[26]);
        #3;
        rst_n = 1'b0;
        #1;
        check("R12 async reset", actual(), '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule